// File: doc/BRIEF.md
# Serial FIFO DMA Request Controller

This block sits between a serial line core and a byte-wide DMA engine. It holds a transmit FIFO and a receive FIFO. It turns the fill level of each FIFO into a DMA request, using a trigger level that software programs. Each DMA acknowledge moves exactly one byte: from memory into the transmit FIFO, or from the head of the receive FIFO out to memory. Bytes in the transmit FIFO are offered to the line side without any further action, and the line side pops them with a ready handshake.

Transmit completion is reported in two ways. In plain serial mode the block is done when the transmit FIFO is empty. In infrared frame mode the line still sends the final byte, the CRC and the stop flag after the FIFO empties. For that mode a separate frame-done flag waits for a completion strobe from the line side. Reception ends on an end-of-frame event from the line side, not when the FIFO drains. That event sets a sticky status bit, which can drive a maskable interrupt.

Top module: `sfifo_dma_ctrl`

## Requirements
- R1: After reset both FIFO levels are 0, `tx_empty_o` is 1, `tx_dma_req_o` is 1, `rx_dma_req_o` is 0, and every sticky flag and `irq_o` is 0.
- R2: `tx_dma_req_o` is high while the transmit level is below the effective transmit trigger. A trigger value of 0 acts as 1. The one exception is the hold-off cycle of R4.
- R3: Each cycle with `tx_dma_ack_i` high writes `tx_dma_data_i` into the transmit FIFO. Each cycle with `rx_dma_ack_i` high consumes the receive FIFO head, which is always presented on `rx_dma_data_o`.
- R4: In the cycle after an acknowledge, the matching request is low. After that it re-asserts only if its trigger condition holds on the updated level.
- R5: While the transmit FIFO is not empty, `line_tx_valid_o` is high and `line_tx_data_o` shows the oldest byte. A cycle with valid and `line_tx_ready_i` both high pops that byte.
- R6: With `irda_mode_i` low, `tx_done_o` equals `tx_empty_o`.
- R7: With `irda_mode_i` high, `tx_done_o` sets only on a `line_frame_done_i` strobe that arrives while the transmit FIFO is empty. A strobe that arrives while the FIFO holds data is ignored. `tx_done_o` clears on the next transmit write.
- R8: `rx_dma_req_o` is high while the receive level is at or above the effective receive trigger (0 acts as 1). With a trigger of 1, every received byte raises a request.
- R9: While `rx_en_i` is low, `line_rx_valid_i` is ignored: the receive level does not change and no overflow is flagged.
- R10: A FIFO holds 64 bytes. A write to a full FIFO is dropped and sets the sticky `tx_ovf_o` or `rx_ovf_o`. A receive-side acknowledge on an empty FIFO is dropped and sets the sticky `rx_unf_o`.
- R11: `line_eof_i` sets the sticky `eof_sts_o`. `eof_clr_i` clears it, but a set in the same cycle wins. `irq_o` is `eof_sts_o` gated by `eof_irq_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irda_mode_i | input | 1 | Infrared frame mode select |
| rx_en_i | input | 1 | Receive enable |
| tx_trig_i | input | 6 | Transmit trigger level |
| rx_trig_i | input | 6 | Receive trigger level |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| tx_dma_ack_i | input | 1 | Transmit DMA byte strobe |
| tx_dma_data_i | input | 8 | Byte from memory |
| rx_dma_req_o | output | 1 | Receive DMA request |
| rx_dma_ack_i | input | 1 | Receive DMA byte strobe |
| rx_dma_data_o | output | 8 | Receive FIFO head byte |
| line_tx_valid_o | output | 1 | Transmit byte available |
| line_tx_data_o | output | 8 | Transmit FIFO head byte |
| line_tx_ready_i | input | 1 | Line side takes the byte |
| line_rx_valid_i | input | 1 | Received byte strobe |
| line_rx_data_i | input | 8 | Received byte |
| line_frame_done_i | input | 1 | CRC and stop flag sent |
| line_eof_i | input | 1 | Reception end-of-frame event |
| tx_level_o | output | 7 | Transmit FIFO fill level |
| rx_level_o | output | 7 | Receive FIFO fill level |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| tx_done_o | output | 1 | Transmission complete |
| tx_ovf_o | output | 1 | Sticky transmit overflow |
| rx_ovf_o | output | 1 | Sticky receive overflow |
| rx_unf_o | output | 1 | Sticky receive underflow |
| eof_sts_o | output | 1 | Sticky end-of-frame status |
| eof_clr_i | input | 1 | Write-one-to-clear strobe for eof_sts_o |
| eof_irq_en_i | input | 1 | End-of-frame interrupt enable |
| irq_o | output | 1 | End-of-frame interrupt |

## Verification
The hardest cases to reach from the ports are the full-FIFO corners. Reaching them takes 64 acknowledges issued regardless of the request line, or 64 line-side pushes with the DMA side held idle. One more transfer is then applied, and the bench checks that the overflowing byte never appears when the FIFO is drained in order. The infrared frame-done path is also hard to reach. For it, the bench holds `line_tx_ready_i` low so that a completion strobe lands while a byte is still queued. It then drains the FIFO and repeats the strobe, to show that only the second strobe takes effect.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic {DIR_FILL, DIR_DRAIN} req_dir_e;
  localparam int unsigned DATA_W = 8;
endpackage

// File: rtl/sdma_fifo.sv
module sdma_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             rd_i,
  output logic [DW-1:0]    rdata_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [LVL_W-1:0] lvl_q;
  logic             wr_ok, rd_ok;

  assign full_o  = (lvl_q == LVL_W'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign wr_ok   = wr_i & ~full_o;
  assign rd_ok   = rd_i & ~empty_o;
  assign rdata_o = mem_q[rptr_q];
  assign level_o = lvl_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
      ovf_o  <= 1'b0;
      unf_o  <= 1'b0;
    end else begin
      if (wr_ok) wptr_q <= nxt(wptr_q);
      if (rd_ok) rptr_q <= nxt(rptr_q);
      case ({wr_ok, rd_ok})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
      if (wr_i && full_o)  ovf_o <= 1'b1;
      if (rd_i && empty_o) unf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sdma_req.sv
module sdma_req
  import sdma_pkg::*;
#(
  parameter int unsigned LVL_W  = 7,
  parameter int unsigned TRIG_W = 6,
  parameter req_dir_e    DIR    = DIR_FILL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [TRIG_W-1:0] trig_i,
  input  logic              ack_i,
  output logic              req_o
);
  logic [LVL_W-1:0] eff_trig;
  logic             cond, holdoff_q;

  assign eff_trig = (trig_i == '0) ? LVL_W'(1) : LVL_W'(trig_i);

  generate
    if (DIR == DIR_FILL) begin : g_fill
      assign cond = (level_i < eff_trig);
    end else begin : g_drain
      assign cond = (level_i >= eff_trig);
    end
  endgenerate

  // one dead cycle after each transfer so the engine never double-moves
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) holdoff_q <= 1'b0;
    else         holdoff_q <= ack_i;
  end

  assign req_o = cond & ~holdoff_q;
endmodule

// File: rtl/sdma_done.sv
module sdma_done (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irda_mode_i,
  input  logic empty_i,
  input  logic tx_wr_i,
  input  logic line_done_i,
  output logic done_o
);
  logic frame_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  frame_done_q <= 1'b0;
    else if (tx_wr_i)                             frame_done_q <= 1'b0;
    else if (irda_mode_i && empty_i && line_done_i) frame_done_q <= 1'b1;
  end

  assign done_o = irda_mode_i ? frame_done_q : empty_i;
endmodule

// File: rtl/sfifo_dma_ctrl.sv
module sfifo_dma_ctrl
  import sdma_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned TRIG_W = $clog2(DEPTH),
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irda_mode_i,
  input  logic              rx_en_i,
  input  logic [TRIG_W-1:0] tx_trig_i,
  input  logic [TRIG_W-1:0] rx_trig_i,
  output logic              tx_dma_req_o,
  input  logic              tx_dma_ack_i,
  input  logic [DW-1:0]     tx_dma_data_i,
  output logic              rx_dma_req_o,
  input  logic              rx_dma_ack_i,
  output logic [DW-1:0]     rx_dma_data_o,
  output logic              line_tx_valid_o,
  output logic [DW-1:0]     line_tx_data_o,
  input  logic              line_tx_ready_i,
  input  logic              line_rx_valid_i,
  input  logic [DW-1:0]     line_rx_data_i,
  input  logic              line_frame_done_i,
  input  logic              line_eof_i,
  output logic [LVL_W-1:0]  tx_level_o,
  output logic [LVL_W-1:0]  rx_level_o,
  output logic              tx_empty_o,
  output logic              tx_done_o,
  output logic              tx_ovf_o,
  output logic              rx_ovf_o,
  output logic              rx_unf_o,
  output logic              eof_sts_o,
  input  logic              eof_clr_i,
  input  logic              eof_irq_en_i,
  output logic              irq_o
);
  logic tx_full_unused, tx_unf_unused, rx_full_unused, rx_empty_unused;
  logic rx_wr, tx_rd, eof_q;

  assign rx_wr = line_rx_valid_i & rx_en_i;
  assign tx_rd = line_tx_valid_o & line_tx_ready_i;
  assign line_tx_valid_o = ~tx_empty_o;

  sdma_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .wr_i(tx_dma_ack_i), .wdata_i(tx_dma_data_i),
    .rd_i(tx_rd), .rdata_o(line_tx_data_o),
    .level_o(tx_level_o), .full_o(tx_full_unused), .empty_o(tx_empty_o),
    .ovf_o(tx_ovf_o), .unf_o(tx_unf_unused)
  );

  sdma_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .wr_i(rx_wr), .wdata_i(line_rx_data_i),
    .rd_i(rx_dma_ack_i), .rdata_o(rx_dma_data_o),
    .level_o(rx_level_o), .full_o(rx_full_unused), .empty_o(rx_empty_unused),
    .ovf_o(rx_ovf_o), .unf_o(rx_unf_o)
  );

  sdma_req #(.LVL_W(LVL_W), .TRIG_W(TRIG_W), .DIR(DIR_FILL)) u_tx_req (
    .clk_i, .rst_ni, .level_i(tx_level_o), .trig_i(tx_trig_i),
    .ack_i(tx_dma_ack_i), .req_o(tx_dma_req_o)
  );

  sdma_req #(.LVL_W(LVL_W), .TRIG_W(TRIG_W), .DIR(DIR_DRAIN)) u_rx_req (
    .clk_i, .rst_ni, .level_i(rx_level_o), .trig_i(rx_trig_i),
    .ack_i(rx_dma_ack_i), .req_o(rx_dma_req_o)
  );

  sdma_done u_done (
    .clk_i, .rst_ni, .irda_mode_i, .empty_i(tx_empty_o),
    .tx_wr_i(tx_dma_ack_i), .line_done_i(line_frame_done_i), .done_o(tx_done_o)
  );

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         eof_q <= 1'b0;
    else if (line_eof_i) eof_q <= 1'b1;
    else if (eof_clr_i)  eof_q <= 1'b0;
  end

  assign eof_sts_o = eof_q;
  assign irq_o     = eof_q & eof_irq_en_i;
endmodule

// File: rtl/sdma_chk.sv
module sdma_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irda_mode_i,
  input logic             rx_en_i,
  input logic             tx_dma_req_o,
  input logic             tx_dma_ack_i,
  input logic             rx_dma_req_o,
  input logic             rx_dma_ack_i,
  input logic             line_rx_valid_i,
  input logic             line_eof_i,
  input logic [LVL_W-1:0] tx_level_o,
  input logic [LVL_W-1:0] rx_level_o,
  input logic             tx_done_o,
  input logic             tx_ovf_o,
  input logic             eof_sts_o
);
  AST_TX_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dma_ack_i |=> !tx_dma_req_o); // R4
  AST_RX_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_ack_i |=> !rx_dma_req_o); // R4
  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level_o <= LVL_W'(DEPTH)) && (rx_level_o <= LVL_W'(DEPTH))); // R10
  AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ovf_o |=> tx_ovf_o); // R10
  AST_RX_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && !rx_dma_ack_i) |=> $stable(rx_level_o)); // R9
  AST_FRAME_DONE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irda_mode_i && tx_dma_ack_i) |=> !tx_done_o); // R7
  AST_EOF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_eof_i |=> eof_sts_o); // R11
  AST_RX_REQ_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_req_o |-> (rx_level_o != '0)); // R8
endmodule

bind sfifo_dma_ctrl sdma_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irda_mode_i(irda_mode_i), .rx_en_i(rx_en_i),
  .tx_dma_req_o(tx_dma_req_o), .tx_dma_ack_i(tx_dma_ack_i),
  .rx_dma_req_o(rx_dma_req_o), .rx_dma_ack_i(rx_dma_ack_i),
  .line_rx_valid_i(line_rx_valid_i), .line_eof_i(line_eof_i),
  .tx_level_o(tx_level_o), .rx_level_o(rx_level_o), .tx_done_o(tx_done_o),
  .tx_ovf_o(tx_ovf_o), .eof_sts_o(eof_sts_o)
);

// File: tb/sim_sfifo_dma_ctrl.sv
`timescale 1ns/1ps
module sim_sfifo_dma_ctrl;
  localparam int DEPTH = 64;
  localparam int TW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic irda = 0, rx_en = 0, tx_ack = 0, rx_ack = 0, tx_rdy = 0, rx_vld = 0;
  logic fdone = 0, eof = 0, eof_clr = 0, eof_en = 0;
  logic [TW-1:0] tx_trig = 4, rx_trig = 1;
  logic [7:0] tx_d = 0, rx_ld = 0;
  logic tx_req, rx_req, tx_vld, tx_empty, tx_done, tx_ovf, rx_ovf, rx_unf, eof_sts, irq;
  logic [7:0] rx_dd, tx_ld;
  logic [LW-1:0] tx_lvl, rx_lvl;
  int vectors = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sfifo_dma_ctrl #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irda_mode_i(irda), .rx_en_i(rx_en),
    .tx_trig_i(tx_trig), .rx_trig_i(rx_trig),
    .tx_dma_req_o(tx_req), .tx_dma_ack_i(tx_ack), .tx_dma_data_i(tx_d),
    .rx_dma_req_o(rx_req), .rx_dma_ack_i(rx_ack), .rx_dma_data_o(rx_dd),
    .line_tx_valid_o(tx_vld), .line_tx_data_o(tx_ld), .line_tx_ready_i(tx_rdy),
    .line_rx_valid_i(rx_vld), .line_rx_data_i(rx_ld),
    .line_frame_done_i(fdone), .line_eof_i(eof),
    .tx_level_o(tx_lvl), .rx_level_o(rx_lvl), .tx_empty_o(tx_empty),
    .tx_done_o(tx_done), .tx_ovf_o(tx_ovf), .rx_ovf_o(rx_ovf), .rx_unf_o(rx_unf),
    .eof_sts_o(eof_sts), .eof_clr_i(eof_clr), .eof_irq_en_i(eof_en), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 tx_level", tx_lvl, 0);
    chk("R1 rx_level", rx_lvl, 0);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 tx_req", tx_req, 1);
    chk("R1 rx_req", rx_req, 0);
    chk("R1 flags", {tx_ovf, rx_ovf, rx_unf, eof_sts, irq}, 0);
    chk("R6 plain done at reset", tx_done, 1);
  endtask

  task automatic t_tx_fill();
    tx_trig = 4;
    for (int i = 0; i < 4; i++) begin
      chk("R2 tx_req below trigger", tx_req, 1);
      tx_ack = 1; tx_d = 8'h10 + 8'(i);
      step();
      tx_ack = 0;
      chk("R4 tx holdoff", tx_req, 0);
      step();
    end
    chk("R3 tx_level", tx_lvl, 4);
    chk("R2 tx_req at trigger", tx_req, 0);
    tx_trig = 0; #1;
    chk("R2 trigger 0 acts as 1", tx_req, 0);
    tx_trig = 5; #1;
    chk("R2 raised trigger", tx_req, 1);
    tx_trig = 4; #1;
  endtask

  task automatic t_tx_drain();
    tx_rdy = 1;
    for (int i = 0; i < 4; i++) begin
      chk("R5 line valid", tx_vld, 1);
      chk("R5 line data order", tx_ld, 8'h10 + i);
      step();
    end
    tx_rdy = 0;
    chk("R5 drained", tx_lvl, 0);
    chk("R6 empty", tx_empty, 1);
    chk("R6 plain done", tx_done, 1);
  endtask

  task automatic t_irda();
    irda = 1; #1;
    chk("R7 irda done not yet", tx_done, 0);
    tx_ack = 1; tx_d = 8'h77; step(); tx_ack = 0;
    fdone = 1; step(); fdone = 0;
    chk("R7 strobe while queued ignored", tx_done, 0);
    tx_rdy = 1; step(); tx_rdy = 0;
    chk("R7 empty but frame open", {tx_empty, tx_done}, 2'b10);
    fdone = 1; step(); fdone = 0;
    chk("R7 frame done", tx_done, 1);
    tx_ack = 1; tx_d = 8'h78; step(); tx_ack = 0;
    chk("R7 cleared by write", tx_done, 0);
    tx_rdy = 1; step(); tx_rdy = 0;
    irda = 0; #1;
  endtask

  task automatic t_rx();
    rx_en = 0; rx_trig = 1;
    rx_vld = 1; rx_ld = 8'hA5; step(); rx_vld = 0;
    chk("R9 disabled rx level", rx_lvl, 0);
    chk("R9 disabled no ovf", rx_ovf, 0);
    rx_en = 1;
    rx_vld = 1; rx_ld = 8'h3C; step(); rx_vld = 0;
    chk("R8 trig 1 request", rx_req, 1);
    chk("R3 rx head data", rx_dd, 8'h3C);
    rx_ack = 1; step(); rx_ack = 0;
    chk("R4 rx holdoff", rx_req, 0);
    chk("R3 rx consumed", rx_lvl, 0);
    step();
    chk("R4 rx no reassert", rx_req, 0);
    rx_trig = 3;
    for (int i = 0; i < 3; i++) begin
      rx_vld = 1; rx_ld = 8'h50 + 8'(i); step(); rx_vld = 0;
      chk("R8 rx trigger 3", rx_req, (i == 2) ? 1 : 0);
    end
    rx_trig = 1;
    for (int i = 0; i < 3; i++) begin
      chk("R3 rx order", rx_dd, 8'h50 + i);
      rx_ack = 1; step(); rx_ack = 0; step();
    end
    chk("R3 rx emptied", rx_lvl, 0);
  endtask

  task automatic t_ovf();
    for (int i = 0; i < DEPTH; i++) begin
      tx_ack = 1; tx_d = 8'(i); step();
    end
    chk("R10 tx full level", tx_lvl, DEPTH);
    chk("R10 no ovf yet", tx_ovf, 0);
    tx_d = 8'hEE; step(); tx_ack = 0;
    chk("R10 tx ovf sticky", tx_ovf, 1);
    chk("R10 tx level held", tx_lvl, DEPTH);
    tx_rdy = 1;
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 0 || i == DEPTH - 1) chk("R10 dropped byte absent", tx_ld, i);
      step();
    end
    tx_rdy = 0;
    chk("R10 tx drained", tx_empty, 1);
    rx_ack = 1; step(); rx_ack = 0;
    chk("R10 rx unf", rx_unf, 1);
    chk("R10 rx level stays 0", rx_lvl, 0);
    rx_vld = 1;
    for (int i = 0; i <= DEPTH; i++) begin
      rx_ld = 8'(i); step();
    end
    rx_vld = 0;
    chk("R10 rx ovf", rx_ovf, 1);
    chk("R10 rx level full", rx_lvl, DEPTH);
  endtask

  task automatic t_eof();
    eof_en = 0;
    eof = 1; step(); eof = 0;
    chk("R11 eof sticky", eof_sts, 1);
    chk("R11 irq masked", irq, 0);
    eof_en = 1; #1;
    chk("R11 irq enabled", irq, 1);
    eof_clr = 1; step(); eof_clr = 0;
    chk("R11 w1c", {eof_sts, irq}, 0);
    eof = 1; eof_clr = 1; step(); eof = 0; eof_clr = 0;
    chk("R11 set wins", eof_sts, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx_fill();
    t_tx_drain();
    t_irda();
    t_rx();
    t_ovf();
    t_eof();
    finish_run();
  end
endmodule